// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store of a 32-bit RISC core that runs in seven operating modes. Software addresses sixteen logical registers (index 15 is the program counter), and the block redirects each index to one of 31 physical 32-bit general registers according to the mode in the current status word. Alongside the general registers it keeps the current status word and five saved status words, one for each privileged mode that owns one. That makes 37 registers in all.

The core's decode stage reads two operands and writes one result per cycle. A user-bank option lets privileged code reach the user-mode copies of R8 to R14. A dedicated exception port switches the mode in a single clock edge. On that edge it stores the return address in the new mode's link register, copies the old status word into the new mode's saved status word, and loads the program counter with the handler address. In the compact 16-bit instruction state, SP, LR and PC are simply logical indices 13, 14 and 15, and R0 to R7 are shared, so the block needs no separate view for that state.

Every port completes in the cycle it is presented. There is no valid/ready handshake and no back-pressure. A request that is ignored leaves no pending state behind.

Top module: `rf_banked_regfile`

## Requirements
- R1: After reset, every general register reads 0 and the current status word is 32'h0000_0013 (supervisor mode).
- R2: The mode is the status field bits [4:0], and `mode_q` presents it. The encodings are: user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011, system 11111.
- R3: Logical R0 to R7 and R15 are the same storage in every mode. User and system modes share all sixteen. Fast-interrupt mode has private R8 to R14. Interrupt, supervisor, abort and undefined modes each have private R13 and R14. An unlisted mode encoding uses the user mapping.
- R4: The two read ports are combinational and the write port takes effect at the clock edge. A read of the register being written in the same cycle returns the old value.
- R5: While `user_bank` is high, both reads and the write use the user-mode mapping, whatever the current mode.
- R6: Each of the five privileged modes other than system has its own saved status word. `spsr_q` and `spsr_wr_en` act on the one belonging to the current mode.
- R7: In user or system mode, `spsr_q` returns the current status word and `spsr_wr_en` changes no register.
- R8: An accepted exception does four things in one edge. It writes `exc_ret_addr` to the target mode's R14, copies the old status word into the target mode's saved status word, replaces status bits [4:0] with `exc_mode` while keeping bits [31:5], and writes `exc_vector` to R15.
- R9: In a cycle with an accepted exception, `wr_en`, `cpsr_wr_en` and `spsr_wr_en` are discarded.
- R10: An exception request whose `exc_mode` is not one of the five modes with a saved status word is ignored, and the other writes of that cycle proceed.
- R11: `cpsr_wr_en` replaces all 32 status bits, and the new mode governs the mapping from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| user_bank | input | 1 | Use the user-mode mapping for reads and the write |
| rd_a_idx | input | 4 | Logical index, read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Logical index, read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | Logical index to write |
| wr_data | input | 32 | Write data |
| cpsr_wr_en | input | 1 | Replace the current status word |
| cpsr_wr_data | input | 32 | New status word |
| cpsr_q | output | 32 | Current status word |
| mode_q | output | 5 | Current mode field |
| spsr_wr_en | input | 1 | Write the current mode's saved status word |
| spsr_wr_data | input | 32 | Saved status write data |
| spsr_q | output | 32 | Current mode's saved status word, or the status word in user/system mode |
| exc_en | input | 1 | Exception entry request |
| exc_mode | input | 5 | Mode to enter |
| exc_ret_addr | input | 32 | Return address for the new link register |
| exc_vector | input | 32 | Handler address loaded into R15 |

## Verification
The checker tests exception entry on every cycle. After an accepted request it confirms the new mode, the saved copy of the old status word, the preserved upper status bits, and the link register and program counter as seen through the read ports. It also confirms that saved-status writes in user or system mode leave the status word alone and that an unacceptable exception target leaves the mode unchanged. Only the directed scenarios can show the banking itself, because they write through one mode and read back through several others. The same applies to the old-value return on a same-cycle read and write and to the user-bank path from fast-interrupt mode.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int MODE_W = 5;
  localparam int NPHYS  = 31;
  localparam int NSPSR  = 5;
  localparam int PAW    = $clog2(NPHYS);
  localparam int SLW    = $clog2(NSPSR);

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  // Physical layout: 0..15 user view, then the private copies of each mode
  localparam int BASE_FIQ = 16;  // R8..R14
  localparam int BASE_SVC = 23;  // R13, R14
  localparam int BASE_ABT = 25;
  localparam int BASE_IRQ = 27;
  localparam int BASE_UND = 29;
  localparam int PC_IDX   = 15;

  typedef struct packed {
    logic           valid;
    logic [SLW-1:0] slot;
  } spsr_sel_t;

  function automatic spsr_sel_t spsr_sel(input logic [MODE_W-1:0] m);
    spsr_sel_t s;
    s = '{valid: 1'b1, slot: '0};
    case (m)
      MODE_FIQ: s.slot = SLW'(0);
      MODE_SVC: s.slot = SLW'(1);
      MODE_ABT: s.slot = SLW'(2);
      MODE_IRQ: s.slot = SLW'(3);
      MODE_UND: s.slot = SLW'(4);
      default:  s.valid = 1'b0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/rf_bank_map.sv
module rf_bank_map
  import rf_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [3:0]        lidx,
  output logic [PAW-1:0]    pidx
);
  logic is_hi;   // R8..R14
  logic is_sp;   // R13, R14
  always_comb begin
    is_hi = (lidx >= 4'd8) && (lidx <= 4'd14);
    is_sp = (lidx == 4'd13) || (lidx == 4'd14);
    pidx  = PAW'(lidx);
    case (mode)
      MODE_FIQ: if (is_hi) pidx = PAW'(BASE_FIQ) + PAW'(lidx - 4'd8);
      MODE_SVC: if (is_sp) pidx = PAW'(BASE_SVC) + PAW'(lidx - 4'd13);
      MODE_ABT: if (is_sp) pidx = PAW'(BASE_ABT) + PAW'(lidx - 4'd13);
      MODE_IRQ: if (is_sp) pidx = PAW'(BASE_IRQ) + PAW'(lidx - 4'd13);
      MODE_UND: if (is_sp) pidx = PAW'(BASE_UND) + PAW'(lidx - 4'd13);
      default:  pidx = PAW'(lidx);
    endcase
  end
endmodule

// File: rtl/rf_gpr_array.sv
module rf_gpr_array
  import rf_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PAW-1:0]  ra_addr,
  output logic [XLEN-1:0] ra_data,
  input  logic [PAW-1:0]  rb_addr,
  output logic [XLEN-1:0] rb_data,
  input  logic            w0_en,
  input  logic [PAW-1:0]  w0_addr,
  input  logic [XLEN-1:0] w0_data,
  input  logic            w1_en,
  input  logic [PAW-1:0]  w1_addr,
  input  logic [XLEN-1:0] w1_data
);
  logic [XLEN-1:0] mem [NPHYS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NPHYS; i++) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (w1_en && (w1_addr == PAW'(i)))
        mem[i] <= w1_data;
      else if (w0_en && (w0_addr == PAW'(i)))
        mem[i] <= w0_data;
    end
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
endmodule

// File: rtl/rf_status_regs.sv
module rf_status_regs
  import rf_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] CPSR_RESET = 32'h0000_0013
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpsr_we,
  input  logic [XLEN-1:0] cpsr_wd,
  output logic [XLEN-1:0] cpsr,
  input  logic            spsr_we,
  input  logic [SLW-1:0]  spsr_wslot,
  input  logic [XLEN-1:0] spsr_wd,
  input  logic [SLW-1:0]  spsr_rslot,
  output logic [XLEN-1:0] spsr_rd
);
  logic [XLEN-1:0] spsr [NSPSR];

  always_ff @(posedge clk) begin
    if (!rst_n)       cpsr <= CPSR_RESET;
    else if (cpsr_we) cpsr <= cpsr_wd;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSPSR; i++) begin
      if (!rst_n)
        spsr[i] <= '0;
      else if (spsr_we && (spsr_wslot == SLW'(i)))
        spsr[i] <= spsr_wd;
    end
  end

  assign spsr_rd = spsr[spsr_rslot];
endmodule

// File: rtl/rf_banked_regfile.sv
module rf_banked_regfile
  import rf_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            user_bank,
  input  logic [3:0]      rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic [3:0]      rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic [3:0]      wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            cpsr_wr_en,
  input  logic [XLEN-1:0] cpsr_wr_data,
  output logic [XLEN-1:0] cpsr_q,
  output logic [4:0]      mode_q,
  input  logic            spsr_wr_en,
  input  logic [XLEN-1:0] spsr_wr_data,
  output logic [XLEN-1:0] spsr_q,
  input  logic            exc_en,
  input  logic [4:0]      exc_mode,
  input  logic [XLEN-1:0] exc_ret_addr,
  input  logic [XLEN-1:0] exc_vector
);
  localparam int NPORT = 4;  // read A, read B, write, exception link

  logic [MODE_W-1:0] cur_mode, acc_mode;
  logic [MODE_W-1:0] map_mode [NPORT];
  logic [3:0]        map_lidx [NPORT];
  logic [PAW-1:0]    map_pidx [NPORT];
  spsr_sel_t         cur_sel, exc_sel;
  logic              exc_ok;

  logic            g0_en, g1_en;
  logic [PAW-1:0]  g0_addr, g1_addr;
  logic [XLEN-1:0] g0_data, g1_data;
  logic            st_cpsr_we, st_spsr_we;
  logic [XLEN-1:0] st_cpsr_wd, st_spsr_wd, st_spsr_rd;
  logic [SLW-1:0]  st_spsr_wslot;

  assign cur_mode = cpsr_q[MODE_W-1:0];
  assign acc_mode = user_bank ? MODE_USR : cur_mode;
  assign cur_sel  = spsr_sel(cur_mode);
  assign exc_sel  = spsr_sel(exc_mode);
  assign exc_ok   = exc_en && exc_sel.valid;

  assign map_mode[0] = acc_mode;  assign map_lidx[0] = rd_a_idx;
  assign map_mode[1] = acc_mode;  assign map_lidx[1] = rd_b_idx;
  assign map_mode[2] = acc_mode;  assign map_lidx[2] = wr_idx;
  assign map_mode[3] = exc_mode;  assign map_lidx[3] = 4'd14;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    rf_bank_map u_map (
      .mode (map_mode[p]),
      .lidx (map_lidx[p]),
      .pidx (map_pidx[p])
    );
  end

  // Port 0 carries the normal write or the new link register;
  // port 1 loads the handler address into the program counter.
  always_comb begin
    g0_en   = exc_ok ? 1'b1 : wr_en;
    g0_addr = exc_ok ? map_pidx[3] : map_pidx[2];
    g0_data = exc_ok ? exc_ret_addr : wr_data;
    g1_en   = exc_ok;
    g1_addr = PAW'(PC_IDX);
    g1_data = exc_vector;
  end

  rf_gpr_array #(.XLEN(XLEN)) u_gpr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ra_addr (map_pidx[0]),
    .ra_data (rd_a_data),
    .rb_addr (map_pidx[1]),
    .rb_data (rd_b_data),
    .w0_en   (g0_en),
    .w0_addr (g0_addr),
    .w0_data (g0_data),
    .w1_en   (g1_en),
    .w1_addr (g1_addr),
    .w1_data (g1_data)
  );

  always_comb begin
    st_cpsr_we    = exc_ok || cpsr_wr_en;
    st_cpsr_wd    = exc_ok ? {cpsr_q[XLEN-1:MODE_W], exc_mode} : cpsr_wr_data;
    st_spsr_we    = exc_ok || (spsr_wr_en && cur_sel.valid);
    st_spsr_wslot = exc_ok ? exc_sel.slot : cur_sel.slot;
    st_spsr_wd    = exc_ok ? cpsr_q : spsr_wr_data;
  end

  rf_status_regs #(.XLEN(XLEN)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpsr_we    (st_cpsr_we),
    .cpsr_wd    (st_cpsr_wd),
    .cpsr       (cpsr_q),
    .spsr_we    (st_spsr_we),
    .spsr_wslot (st_spsr_wslot),
    .spsr_wd    (st_spsr_wd),
    .spsr_rslot (cur_sel.slot),
    .spsr_rd    (st_spsr_rd)
  );

  assign spsr_q = cur_sel.valid ? st_spsr_rd : cpsr_q;
  assign mode_q = cur_mode;
endmodule

// File: rtl/rf_banked_regfile_chk.sv
module rf_banked_regfile_chk
  import rf_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            user_bank,
  input logic [3:0]      rd_a_idx,
  input logic [XLEN-1:0] rd_a_data,
  input logic [3:0]      rd_b_idx,
  input logic [XLEN-1:0] rd_b_data,
  input logic            wr_en,
  input logic [3:0]      wr_idx,
  input logic [XLEN-1:0] wr_data,
  input logic            cpsr_wr_en,
  input logic [XLEN-1:0] cpsr_wr_data,
  input logic [XLEN-1:0] cpsr_q,
  input logic [4:0]      mode_q,
  input logic            spsr_wr_en,
  input logic [XLEN-1:0] spsr_wr_data,
  input logic [XLEN-1:0] spsr_q,
  input logic            exc_en,
  input logic [4:0]      exc_mode,
  input logic [XLEN-1:0] exc_ret_addr,
  input logic [XLEN-1:0] exc_vector
);
  logic acc_exc, bad_exc, usr_like;
  assign acc_exc  = exc_en && spsr_sel(exc_mode).valid;
  assign bad_exc  = exc_en && !spsr_sel(exc_mode).valid;
  assign usr_like = (mode_q == MODE_USR) || (mode_q == MODE_SYS);

  assert_exc_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_exc |=> mode_q == $past(exc_mode));

  assert_exc_saves_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_exc |=> spsr_q == $past(cpsr_q));

  assert_exc_link_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_exc |=> (rd_a_idx != 4'd14 || user_bank || rd_a_data == $past(exc_ret_addr)));

  assert_exc_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_exc |=> (rd_b_idx != 4'd15 || rd_b_data == $past(exc_vector)));

  assert_exc_over_cpsr_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_exc |=> cpsr_q[XLEN-1:MODE_W] == $past(cpsr_q[XLEN-1:MODE_W]));

  assert_spsr_write_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (usr_like && spsr_wr_en && !cpsr_wr_en && !exc_en) |=> ($stable(cpsr_q) && spsr_q == cpsr_q));

  assert_bad_exc_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_exc && !cpsr_wr_en) |=> $stable(cpsr_q));
endmodule

bind rf_banked_regfile rf_banked_regfile_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/rf_banked_regfile_test.sv
module rf_banked_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        user_bank = 1'b0;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data;
  logic        wr_en = 1'b0, cpsr_wr_en = 1'b0, spsr_wr_en = 1'b0, exc_en = 1'b0;
  logic [31:0] wr_data = '0, cpsr_wr_data = '0, spsr_wr_data = '0;
  logic [31:0] cpsr_q, spsr_q, exc_ret_addr = '0, exc_vector = '0;
  logic [4:0]  mode_q, exc_mode = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  rf_banked_regfile uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic rd(input logic [3:0] idx, input logic ub, output logic [31:0] v);
    rd_a_idx = idx; user_bank = ub; #1; v = rd_a_data; user_bank = 1'b0;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d, input logic ub);
    wr_en = 1'b1; wr_idx = idx; wr_data = d; user_bank = ub;
    tick();
    wr_en = 1'b0; user_bank = 1'b0;
  endtask

  task automatic set_cpsr(input logic [31:0] v);
    cpsr_wr_en = 1'b1; cpsr_wr_data = v;
    tick();
    cpsr_wr_en = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [3:0] idx, input logic ub,
                            input logic [31:0] exp);
    logic [31:0] v;
    rd(idx, ub, v);
    check(req, v, exp);
  endtask

  task automatic t_reset();
    check("R1 cpsr", cpsr_q, 32'h0000_0013);
    check("R1 mode", {27'd0, mode_q}, 32'h13);
    expect_reg("R1 r0", 4'd0, 1'b0, 32'h0);
    expect_reg("R1 r14", 4'd14, 1'b0, 32'h0);
  endtask

  task automatic t_banking();
    for (int i = 0; i < 16; i++) wr(4'(i), 32'hA000_0000 | i, 1'b0);  // supervisor
    set_cpsr(32'h0000_0010);
    check("R11 cpsr", cpsr_q, 32'h0000_0010);
    check("R2 user", {27'd0, mode_q}, 32'h10);
    for (int i = 0; i < 13; i++) expect_reg("R3 user shared", 4'(i), 1'b0, 32'hA000_0000 | i);
    expect_reg("R3 user pc", 4'd15, 1'b0, 32'hA000_000F);
    expect_reg("R3 user r13", 4'd13, 1'b0, 32'h0);
    expect_reg("R3 user r14", 4'd14, 1'b0, 32'h0);
    wr(4'd13, 32'hB000_000D, 1'b0);
    wr(4'd14, 32'hB000_000E, 1'b0);
    wr(4'd8,  32'hB000_0008, 1'b0);
    set_cpsr(32'h0000_0011);
    check("R2 fiq", {27'd0, mode_q}, 32'h11);
    for (int i = 8; i < 15; i++) expect_reg("R3 fiq private", 4'(i), 1'b0, 32'h0);
    expect_reg("R3 fiq r0", 4'd0, 1'b0, 32'hA000_0000);
    wr(4'd8, 32'hC000_0008, 1'b0);
    set_cpsr(32'h0000_001F);
    expect_reg("R3 sys r8", 4'd8, 1'b0, 32'hB000_0008);
    expect_reg("R3 sys r13", 4'd13, 1'b0, 32'hB000_000D);
    set_cpsr(32'h0000_0012);
    expect_reg("R3 irq r8", 4'd8, 1'b0, 32'hB000_0008);
    expect_reg("R3 irq r12", 4'd12, 1'b0, 32'hA000_000C);
    expect_reg("R3 irq r13", 4'd13, 1'b0, 32'h0);
    set_cpsr(32'h0000_0013);
    expect_reg("R3 svc r13", 4'd13, 1'b0, 32'hA000_000D);
    set_cpsr(32'h0000_0015);
    expect_reg("R3 unknown mode r13", 4'd13, 1'b0, 32'hB000_000D);
  endtask

  task automatic t_read_old();
    set_cpsr(32'h0000_0010);
    rd_a_idx = 4'd3; rd_b_idx = 4'd3;
    wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'h3333_3333;
    #1;
    check("R4 port a old", rd_a_data, 32'hA000_0003);
    check("R4 port b old", rd_b_data, 32'hA000_0003);
    tick();
    wr_en = 1'b0;
    check("R4 port a new", rd_a_data, 32'h3333_3333);
    check("R4 port b new", rd_b_data, 32'h3333_3333);
  endtask

  task automatic t_user_bank();
    set_cpsr(32'h0000_0011);
    expect_reg("R5 fiq reads user r9", 4'd9, 1'b1, 32'hA000_0009);
    wr(4'd9, 32'hD000_0009, 1'b1);
    expect_reg("R5 fiq r9 untouched", 4'd9, 1'b0, 32'h0);
    expect_reg("R5 fiq r8 own", 4'd8, 1'b0, 32'hC000_0008);
    set_cpsr(32'h0000_0010);
    expect_reg("R5 user r9 written", 4'd9, 1'b0, 32'hD000_0009);
  endtask

  task automatic t_spsr();
    set_cpsr(32'h0000_0013);
    spsr_wr_en = 1'b1; spsr_wr_data = 32'h0000_00A5; tick(); spsr_wr_en = 1'b0;
    check("R6 svc spsr", spsr_q, 32'h0000_00A5);
    set_cpsr(32'h0000_0012);
    check("R6 irq spsr fresh", spsr_q, 32'h0);
    spsr_wr_en = 1'b1; spsr_wr_data = 32'h0000_005A; tick(); spsr_wr_en = 1'b0;
    set_cpsr(32'h0000_0013);
    check("R6 svc spsr kept", spsr_q, 32'h0000_00A5);
    set_cpsr(32'h0000_0010);
    check("R7 user spsr mirrors", spsr_q, 32'h0000_0010);
    spsr_wr_en = 1'b1; spsr_wr_data = 32'hFFFF_FFFF; tick(); spsr_wr_en = 1'b0;
    check("R7 user write dropped cpsr", cpsr_q, 32'h0000_0010);
    check("R7 user write dropped spsr", spsr_q, 32'h0000_0010);
    set_cpsr(32'h0000_001F);
    check("R7 sys spsr mirrors", spsr_q, 32'h0000_001F);
    set_cpsr(32'h0000_0013);
    check("R7 svc after user write", spsr_q, 32'h0000_00A5);
    set_cpsr(32'h0000_0012);
    check("R7 irq after user write", spsr_q, 32'h0000_005A);
  endtask

  task automatic t_exception();
    set_cpsr(32'hF000_0010);
    exc_en = 1'b1; exc_mode = 5'b10111; exc_ret_addr = 32'h0000_1234; exc_vector = 32'h0000_0010;
    wr_en = 1'b1; wr_idx = 4'd0; wr_data = 32'hDEAD_BEEF;
    cpsr_wr_en = 1'b1; cpsr_wr_data = 32'h0;
    spsr_wr_en = 1'b1; spsr_wr_data = 32'h7777_7777;
    tick();
    exc_en = 1'b0; wr_en = 1'b0; cpsr_wr_en = 1'b0; spsr_wr_en = 1'b0;
    check("R8 cpsr mode", cpsr_q, 32'hF000_0017);
    check("R8 saved status", spsr_q, 32'hF000_0010);
    expect_reg("R8 link", 4'd14, 1'b0, 32'h0000_1234);
    expect_reg("R8 pc", 4'd15, 1'b0, 32'h0000_0010);
    expect_reg("R8 user link kept", 4'd14, 1'b1, 32'hB000_000E);
    expect_reg("R9 write dropped", 4'd0, 1'b0, 32'hA000_0000);
    exc_en = 1'b1; exc_mode = 5'b11011; exc_ret_addr = 32'h0000_2000; exc_vector = 32'h0000_0004;
    tick();
    exc_en = 1'b0;
    check("R8 nested cpsr", cpsr_q, 32'hF000_001B);
    check("R8 nested spsr", spsr_q, 32'hF000_0017);
    expect_reg("R8 nested link", 4'd14, 1'b0, 32'h0000_2000);
  endtask

  task automatic t_bad_exception();
    exc_en = 1'b1; exc_mode = 5'b10000; exc_ret_addr = 32'h9999_9999; exc_vector = 32'h40;
    wr_en = 1'b1; wr_idx = 4'd1; wr_data = 32'h1111_2222;
    tick();
    exc_en = 1'b0; wr_en = 1'b0;
    check("R10 mode kept", cpsr_q, 32'hF000_001B);
    expect_reg("R10 pc kept", 4'd15, 1'b0, 32'h0000_0004);
    expect_reg("R10 link kept", 4'd14, 1'b0, 32'h0000_2000);
    expect_reg("R10 write proceeds", 4'd1, 1'b0, 32'h1111_2222);
    exc_en = 1'b1; exc_mode = 5'b11111;
    tick();
    exc_en = 1'b0;
    check("R10 system target ignored", cpsr_q, 32'hF000_001B);
  endtask

  initial begin : wd
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset();
    t_banking();
    t_read_old();
    t_user_bank();
    t_spsr();
    t_exception();
    t_bad_exception();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule